// File: doc/BRIEF.md
# Standard-Definition Sync Timing Decoder

This block recovers line and field timing for a standard-definition 10-bit video input. A two-bit mode selects one of four decoding schemes. Mode 0 reads the 4-word timing codes embedded in the pixel stream. Modes 1 to 3 read discrete active-low sync pins, and the field parity comes from how the HSYNC edges relate to the VSYNC or FIELD edges.

The block emits these signals for a downstream pixel counter: single-cycle line-start, field-start and frame-start pulses, a held odd/even flag and a blank flag. In Mode 0 it also presents the decoded H, V and F levels. These levels carry a drive enable that is raised when master operation is selected, so that they can be put out on the sync pins.

Top module: `sd_sync_decoder`

## Requirements
- R1: During and after reset, before any input event, all pulse outputs are 0, odd_field_o is 1, drv_en_o is 0 and the H, V and F levels are 0.
- R2: In mode 0 (mode_i=0), the word sequence 0x3FF, 0x000, 0x000 followed by a fourth word is a timing code. Bit 8 of the fourth word is F, bit 7 is V and bit 6 is H, with H=1 meaning end of active video. The levels h_drv_o, v_drv_o and f_drv_o take the new values one clock after the fourth word is sampled.
- R3: In mode 0, a valid code with H=1 gives a one-cycle line_start_o pulse two clocks after its fourth word is sampled. A code with H=0 gives no pulse.
- R4: In mode 0, a fourth word is ignored and all levels and pulses are left unchanged when either of these holds: bit 9 is not 1, or bits 5..2 do not equal {V^H, F^H, F^V, F^V^H}. A broken preamble is also ignored.
- R5: In mode 0, a valid code whose F differs from the stored F gives a field_start_o pulse, and odd_field_o becomes ~F. When the new F is 0 (odd field), frame_start_o pulses as well.
- R6: drv_en_o is 1 only when master_i=1 and mode_i=0. In mode 0, blank_o equals H|V of the last valid code.
- R7: In modes 1 to 3, each falling edge of hsync_i gives a line_start_o pulse two clocks after the low level is first sampled.
- R8: In mode 1, a FIELD edge sampled while HSYNC is low starts a field, and odd_field_o becomes the inverse of the new FIELD level (0 means odd). A start into an odd field also pulses frame_start_o. A FIELD edge while HSYNC is high is ignored.
- R9: Mode 3 behaves as mode 1, except that FIELD edges count only while HSYNC is high and are ignored while it is low.
- R10: In mode 2, HSYNC and VSYNC falling in the same sampled cycle start an odd field and a frame. A VSYNC fall while HSYNC is high starts an even field. A VSYNC fall while HSYNC stays low is ignored.
- R11: In modes 1 to 3 with blank_en_i=1, blank_o is the inverse of the active-low blank_i, one clock late. With blank_en_i=0, blank_o is 1 while HSYNC is low, or until VBL_LINES line starts have followed the last field start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Decoding mode 0..3 |
| master_i | input | 1 | Master operation select |
| blank_en_i | input | 1 | Use the external blank pin |
| pix_i | input | 10 | Pixel data word |
| hsync_i | input | 1 | Horizontal sync, active low |
| vsync_i | input | 1 | Vertical sync, active low |
| field_i | input | 1 | Field level, 0 = odd |
| blank_i | input | 1 | Blank pin, active low |
| line_start_o | output | 1 | Line start pulse |
| field_start_o | output | 1 | Field start pulse |
| frame_start_o | output | 1 | Frame start pulse |
| odd_field_o | output | 1 | Current field is odd |
| blank_o | output | 1 | Blank flag |
| drv_en_o | output | 1 | Enable for the H/V/F level drive |
| h_drv_o | output | 1 | Decoded H level |
| v_drv_o | output | 1 | Decoded V level |
| f_drv_o | output | 1 | Decoded F level |

## Verification
The hardest situation to reach is a field edge whose HSYNC qualifier is sampled in exactly the same clock as the edge. Both pins are registered, so the qualifying level and the edge must already be in place together one cycle before the decision. The directed tasks hold HSYNC steady for several cycles before toggling FIELD or VSYNC alone, and they make the mode 2 odd-field case by driving both pins low at one negative edge. Corrupted protection bits and broken preambles are sent between valid codes, to show that the stored levels survive.

// File: rtl/sd_sync_pkg.sv
package sd_sync_pkg;
  localparam int PIX_W = 10;

  typedef enum logic [1:0] {
    MODE_CODE    = 2'd0,
    MODE_HF_LOW  = 2'd1,
    MODE_HV      = 2'd2,
    MODE_HF_HIGH = 2'd3
  } sync_mode_e;

  typedef struct packed {
    logic f;
    logic v;
    logic h;
  } fvh_t;

  localparam logic [PIX_W-1:0] PRE_W0 = 10'h3FF;
  localparam logic [PIX_W-1:0] PRE_W1 = 10'h000;

  // protection check of the fourth code word
  function automatic logic xy_ok(input logic [PIX_W-1:0] w);
    logic f, v, h;
    f = w[8]; v = w[7]; h = w[6];
    return w[9] && (w[5:2] == {v ^ h, f ^ h, f ^ v, f ^ v ^ h});
  endfunction
endpackage

// File: rtl/sd_sync_pin_edge.sv
module sd_sync_pin_edge #(
  parameter int N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] fall_o,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] cur_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q  <= '1;
      prev_q <= '1;
    end else begin
      cur_q  <= pin_i;
      prev_q <= cur_q;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_edge
    assign fall_o[i] = prev_q[i] & ~cur_q[i];
    assign rise_o[i] = ~prev_q[i] & cur_q[i];
  end

  assign lvl_o = cur_q;
endmodule

// File: rtl/sd_sync_code_parser.sv
module sd_sync_code_parser
  import sd_sync_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PIX_W-1:0] pix_i,
  output logic             vld_o,
  output logic             f_chg_o,
  output fvh_t             fvh_o
);
  logic [PIX_W-1:0] w0_q, w1_q, w2_q;
  logic             vld_q, f_chg_q;
  fvh_t             fvh_q;
  logic             pre_hit, hit;

  assign pre_hit = (w2_q == PRE_W0) && (w1_q == PRE_W1) && (w0_q == PRE_W1);
  assign hit     = pre_hit && xy_ok(pix_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      w0_q    <= '0;
      w1_q    <= '0;
      w2_q    <= '0;
      vld_q   <= 1'b0;
      f_chg_q <= 1'b0;
      fvh_q   <= '0;
    end else begin
      w2_q  <= w1_q;
      w1_q  <= w0_q;
      w0_q  <= pix_i;
      vld_q <= hit;
      if (hit) begin
        f_chg_q <= pix_i[8] ^ fvh_q.f;
        fvh_q   <= '{f: pix_i[8], v: pix_i[7], h: pix_i[6]};
      end
    end
  end

  assign vld_o   = vld_q;
  assign f_chg_o = f_chg_q;
  assign fvh_o   = fvh_q;
endmodule

// File: rtl/sd_sync_pin_field.sv
module sd_sync_pin_field
  import sd_sync_pkg::*;
(
  input  sync_mode_e mode_i,
  input  logic       h_lvl_i,
  input  logic       h_fall_i,
  input  logic       v_fall_i,
  input  logic       f_lvl_i,
  input  logic       f_edge_i,
  output logic       evt_o,
  output logic       odd_o
);
  always_comb begin
    evt_o = 1'b0;
    odd_o = 1'b0;
    unique case (mode_i)
      MODE_HF_LOW: begin
        evt_o = f_edge_i & ~h_lvl_i;
        odd_o = ~f_lvl_i;
      end
      MODE_HF_HIGH: begin
        evt_o = f_edge_i & h_lvl_i;
        odd_o = ~f_lvl_i;
      end
      MODE_HV: begin
        // coincident fall -> odd; vsync fall under high hsync -> even
        evt_o = v_fall_i & (h_fall_i | h_lvl_i);
        odd_o = h_fall_i;
      end
      default: begin
        evt_o = 1'b0;
        odd_o = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/sd_sync_decoder.sv
module sd_sync_decoder
  import sd_sync_pkg::*;
#(
  parameter int VBL_LINES = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       mode_i,
  input  logic             master_i,
  input  logic             blank_en_i,
  input  logic [PIX_W-1:0] pix_i,
  input  logic             hsync_i,
  input  logic             vsync_i,
  input  logic             field_i,
  input  logic             blank_i,
  output logic             line_start_o,
  output logic             field_start_o,
  output logic             frame_start_o,
  output logic             odd_field_o,
  output logic             blank_o,
  output logic             drv_en_o,
  output logic             h_drv_o,
  output logic             v_drv_o,
  output logic             f_drv_o
);
  localparam int VC_W = $clog2(VBL_LINES + 1);
  localparam logic [VC_W-1:0] VC_MAX = VC_W'(VBL_LINES);

  sync_mode_e mode;
  assign mode = sync_mode_e'(mode_i);

  logic [3:0] p_lvl, p_fall, p_rise;
  sd_sync_pin_edge #(.N(4)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  ({blank_i, field_i, vsync_i, hsync_i}),
    .lvl_o  (p_lvl),
    .fall_o (p_fall),
    .rise_o (p_rise)
  );

  logic code_vld, code_f_chg;
  fvh_t code_fvh;
  sd_sync_code_parser u_code (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pix_i   (pix_i),
    .vld_o   (code_vld),
    .f_chg_o (code_f_chg),
    .fvh_o   (code_fvh)
  );

  logic pin_evt, pin_odd;
  sd_sync_pin_field u_field (
    .mode_i   (mode),
    .h_lvl_i  (p_lvl[0]),
    .h_fall_i (p_fall[0]),
    .v_fall_i (p_fall[1]),
    .f_lvl_i  (p_lvl[2]),
    .f_edge_i (p_fall[2] | p_rise[2]),
    .evt_o    (pin_evt),
    .odd_o    (pin_odd)
  );

  logic ls_d, fs_d, odd_d, upd_d;
  always_comb begin
    if (mode == MODE_CODE) begin
      ls_d  = code_vld & code_fvh.h;
      fs_d  = code_vld & code_f_chg;
      odd_d = ~code_fvh.f;
      upd_d = code_vld;
    end else begin
      ls_d  = p_fall[0];
      fs_d  = pin_evt;
      odd_d = pin_odd;
      upd_d = pin_evt;
    end
  end

  logic            ls_q, fs_q, fr_q, odd_q;
  logic [VC_W-1:0] vcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ls_q   <= 1'b0;
      fs_q   <= 1'b0;
      fr_q   <= 1'b0;
      odd_q  <= 1'b1;
      vcnt_q <= '0;
    end else begin
      ls_q <= ls_d;
      fs_q <= fs_d;
      fr_q <= fs_d & odd_d;
      if (upd_d) odd_q <= odd_d;
      if (fs_d) vcnt_q <= '0;
      else if (ls_d && vcnt_q < VC_MAX) vcnt_q <= vcnt_q + 1'b1;
    end
  end

  always_comb begin
    if (mode == MODE_CODE) blank_o = code_fvh.h | code_fvh.v;
    else if (blank_en_i)   blank_o = ~p_lvl[3];
    else                   blank_o = ~p_lvl[0] | (vcnt_q < VC_MAX);
  end

  assign line_start_o  = ls_q;
  assign field_start_o = fs_q;
  assign frame_start_o = fr_q;
  assign odd_field_o   = odd_q;
  assign drv_en_o      = master_i & (mode == MODE_CODE);
  assign h_drv_o       = code_fvh.h;
  assign v_drv_o       = code_fvh.v;
  assign f_drv_o       = code_fvh.f;
endmodule

// File: rtl/sd_sync_decoder_chk.sv
module sd_sync_decoder_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] mode_i,
  input logic       line_start_o,
  input logic       field_start_o,
  input logic       frame_start_o,
  input logic       odd_field_o,
  input logic       h_drv_o
);
  a_r3_line_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_start_o |=> !line_start_o);

  a_r5_frame_odd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |-> (field_start_o && odd_field_o));

  a_r8_even_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (field_start_o && !frame_start_o) |-> !odd_field_o);

  a_r10_parity_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!field_start_o && mode_i != 2'd0) |-> $stable(odd_field_o));

  a_r2_eav_sets_h: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_start_o && mode_i == 2'd0) |-> h_drv_o);
endmodule

bind sd_sync_decoder sd_sync_decoder_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .mode_i        (mode_i),
  .line_start_o  (line_start_o),
  .field_start_o (field_start_o),
  .frame_start_o (frame_start_o),
  .odd_field_o   (odd_field_o),
  .h_drv_o       (h_drv_o)
);

// File: tb/sd_sync_decoder_bench.sv
module sd_sync_decoder_bench;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [1:0] mode_i = 2'd0;
  logic master_i = 1'b0, blank_en_i = 1'b0;
  logic [9:0] pix_i = 10'h200;
  logic hsync_i = 1'b1, vsync_i = 1'b1, field_i = 1'b1, blank_i = 1'b1;
  logic line_start_o, field_start_o, frame_start_o, odd_field_o, blank_o;
  logic drv_en_o, h_drv_o, v_drv_o, f_drv_o;

  int n_chk = 0, n_fail = 0;

  always #10 clk_i = ~clk_i;

  sd_sync_decoder #(.VBL_LINES(4)) u_sd_sync_decoder (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [9:0] xy(input logic f, v, h);
    return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h, 2'b00};
  endfunction

  // drive four code words; check levels then pulses
  task automatic send_code(input logic [9:0] w1, w2, w3,
                           output logic [2:0] lvl, output logic [2:0] pls);
    @(negedge clk_i) pix_i = 10'h3FF;
    @(negedge clk_i) pix_i = w1;
    @(negedge clk_i) pix_i = w2;
    @(negedge clk_i) pix_i = w3;
    @(negedge clk_i) pix_i = 10'h200;
    lvl = {f_drv_o, v_drv_o, h_drv_o};
    @(negedge clk_i);
    pls = {frame_start_o, field_start_o, line_start_o};
  endtask

  task automatic t_reset;
    chk("R1 line", line_start_o, 0);
    chk("R1 field", field_start_o, 0);
    chk("R1 frame", frame_start_o, 0);
    chk("R1 odd", odd_field_o, 1);
    chk("R1 drv", {drv_en_o, h_drv_o, v_drv_o, f_drv_o}, 0);
  endtask

  task automatic t_code;
    logic [2:0] l, p;
    mode_i = 2'd0; master_i = 1'b1;
    @(negedge clk_i);
    chk("R6 drv_en master", drv_en_o, 1);
    send_code(10'h000, 10'h000, xy(0, 1, 1), l, p);
    chk("R2 eav levels", l, 3'b011);
    chk("R3 eav pulses", p, 3'b001);
    chk("R6 blank hv", blank_o, 1);
    send_code(10'h000, 10'h000, xy(0, 0, 0), l, p);
    chk("R2 sav levels", l, 3'b000);
    chk("R3 sav no pulse", p, 3'b000);
    chk("R6 blank active", blank_o, 0);
    send_code(10'h000, 10'h000, xy(1, 1, 1), l, p);
    chk("R5 even field pulses", p, 3'b011);
    chk("R5 even parity", odd_field_o, 0);
    send_code(10'h000, 10'h000, xy(0, 1, 1) ^ 10'h004, l, p);
    chk("R4 bad prot levels", l, 3'b111);
    chk("R4 bad prot pulses", p, 3'b000);
    send_code(10'h000, 10'h000, xy(0, 1, 1) & 10'h1FF, l, p);
    chk("R4 bit9 clear levels", l, 3'b111);
    send_code(10'h000, 10'h001, xy(0, 0, 1), l, p);
    chk("R4 broken preamble", {l, p}, {3'b111, 3'b000});
    send_code(10'h000, 10'h000, xy(0, 1, 1), l, p);
    chk("R5 odd frame pulses", p, 3'b111);
    chk("R5 odd parity", odd_field_o, 1);
    master_i = 1'b0;
    @(negedge clk_i);
    chk("R6 drv_en slave", drv_en_o, 0);
  endtask

  task automatic edge_wait(output logic [2:0] pls);
    @(negedge clk_i);
    @(negedge clk_i);
    pls = {frame_start_o, field_start_o, line_start_o};
  endtask

  task automatic settle;
    repeat (3) @(negedge clk_i);
  endtask

  task automatic t_mode1;
    logic [2:0] p;
    mode_i = 2'd1; hsync_i = 1; field_i = 1;
    settle();
    hsync_i = 0;
    edge_wait(p);
    chk("R7 hsync fall line", p, 3'b001);
    settle();
    field_i = 0;
    edge_wait(p);
    chk("R8 odd start", p, 3'b110);
    chk("R8 odd parity", odd_field_o, 1);
    hsync_i = 1;
    settle();
    field_i = 1;
    edge_wait(p);
    chk("R8 high ignored", p, 3'b000);
    chk("R8 parity kept", odd_field_o, 1);
    hsync_i = 0;
    settle();
    field_i = 0;
    settle();
    field_i = 1;
    edge_wait(p);
    chk("R8 even start", p, 3'b010);
    chk("R8 even parity", odd_field_o, 0);
    hsync_i = 1;
  endtask

  task automatic t_mode3;
    logic [2:0] p;
    mode_i = 2'd3; hsync_i = 1; field_i = 1;
    settle();
    field_i = 0;
    edge_wait(p);
    chk("R9 odd start", p, 3'b110);
    hsync_i = 0;
    settle();
    field_i = 1;
    edge_wait(p);
    chk("R9 low ignored", p, 3'b000);
    chk("R9 parity kept", odd_field_o, 1);
    hsync_i = 1;
    settle();
  endtask

  task automatic t_mode2;
    logic [2:0] p;
    mode_i = 2'd2; hsync_i = 1; vsync_i = 1;
    settle();
    hsync_i = 0; vsync_i = 0;
    edge_wait(p);
    chk("R10 coincident odd", p, 3'b111);
    chk("R10 odd parity", odd_field_o, 1);
    hsync_i = 1; vsync_i = 1;
    settle();
    vsync_i = 0;
    edge_wait(p);
    chk("R10 even start", p, 3'b010);
    chk("R10 even parity", odd_field_o, 0);
    vsync_i = 1; hsync_i = 0;
    settle();
    vsync_i = 0;
    edge_wait(p);
    chk("R10 low hsync ignored", p, 3'b000);
    chk("R10 parity kept", odd_field_o, 0);
    vsync_i = 1; hsync_i = 1;
    settle();
  endtask

  task automatic t_blank;
    logic [2:0] p;
    mode_i = 2'd1; blank_en_i = 1; blank_i = 0;
    @(negedge clk_i);
    chk("R11 pin blank", blank_o, 1);
    blank_i = 1;
    @(negedge clk_i);
    chk("R11 pin active", blank_o, 0);
    blank_en_i = 0;
    hsync_i = 0;
    settle();
    field_i = ~field_i;
    edge_wait(p);
    chk("R11 field start", p[1], 1);
    hsync_i = 1;
    @(negedge clk_i);
    chk("R11 vbl blank", blank_o, 1);
    for (int i = 0; i < 3; i++) begin
      hsync_i = 0; @(negedge clk_i);
      hsync_i = 1; @(negedge clk_i);
    end
    settle();
    chk("R11 still vbl", blank_o, 1);
    hsync_i = 0; @(negedge clk_i);
    hsync_i = 1; settle();
    chk("R11 past vbl", blank_o, 0);
    hsync_i = 0;
    @(negedge clk_i);
    chk("R11 hblank", blank_o, 1);
    hsync_i = 1;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual expired expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_code();
    t_mode1();
    t_mode3();
    t_mode2();
    t_blank();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule